// File: doc/BRIEF.md
# Composite Sync Separator

This block receives a digitized, active-low composite sync stream sampled on the system clock. It produces a one-cycle horizontal pulse for each sync falling edge and a one-cycle vertical pulse once per vertical interval. A slower periodic timing input sets the pace of vertical pulse generation. A long sync-low interval marks a vertical candidate. Depending on a mode input, the vertical pulse is emitted either on the next rising edge of the timing input, or only when a sync falling edge appears inside the next low phase of that timing input.

Both inputs pass through a synchronizer before any edge detection. After reset the pulse outputs stay quiet for a set number of timing periods while the upstream reference timing settles. A shape flag compares two samples of sync taken at fixed offsets after each qualification. It tells a plain long-low vertical pulse apart from one that carries serrations.

Top module: `sync_separator`

## Requirements
- R1: While reset is high and on the first cycle after reset, `hsep_o`, `vsep_o` and `shape_o` are 0.
- R2: Each 1-to-0 transition of `csync_n` produces `hsep_o` high for exactly one cycle. The pulse appears after the third rising clock edge that follows the input change (two synchronizer flops plus one output register).
- R3: After reset, `hsep_o` and `vsep_o` stay 0 until `SETTLE_PERIODS` rising edges of `timing_in` have been seen.
- R4: A vertical candidate qualifies when `csync_n` stays low for at least `LOW_THR` consecutive clock cycles. A low interval of `LOW_THR-1` cycles does not qualify.
- R5: With mode 0 (`vmode`=0 at qualification), `vsep_o` pulses on the first rising edge of `timing_in` after qualification, with the same three-edge latency as R2.
- R6: With mode 1, the block waits for the next falling edge of `timing_in` and then watches that low phase. `vsep_o` pulses at the closing rising edge only if a `csync_n` falling edge was seen in the phase. A falling edge in the same cycle as that rising edge counts. A timing rise before the low phase starts gives no pulse.
- R7: The low-width counter saturates. A low interval of any length qualifies at most once, so later timing edges during that same low interval produce no further vertical pulse.
- R8: `vmode` is sampled at qualification. A change of `vmode` afterwards does not alter the pending decision.
- R9: `shape_o` updates once per qualification, `OFF_B` cycles after it, to the XOR of synchronized sync sampled `OFF_A` and `OFF_B` cycles after qualification. It reads 0 when the two samples match and 1 when they differ.
- R10: `vsep_o` is never high for two cycles in a row. `hsep_o` and `vsep_o` may be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Digitized composite sync, active low |
| timing_in | input | 1 | Periodic timing signal pacing vertical pulses |
| vmode | input | 1 | Vertical method select: 0 next-rise, 1 falling-edge qualified |
| hsep_o | output | 1 | One-cycle horizontal sync pulse |
| vsep_o | output | 1 | One-cycle vertical sync pulse |
| shape_o | output | 1 | Vertical-region shape flag (0 match, 1 mismatch) |

## Verification
A horizontal pulse and a vertical pulse can fall in the same cycle. In mode 1 this happens when a sync falling edge arrives with the timing rise that closes the watched low phase. The bench drives both input transitions on the same clock and then checks two things. It expects both outputs to pulse in the same sampled cycle. It also expects the coinciding falling edge to count as the qualifying edge, so the vertical pulse is present.

// File: rtl/sep_pkg.sv
package sep_pkg;
  typedef enum logic [1:0] {
    VS_IDLE      = 2'd0,
    VS_WAIT_RISE = 2'd1,
    VS_WAIT_LOW  = 2'd2,
    VS_WATCH     = 2'd3
  } vstate_e;
endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];

  generate
    for (genvar b = 0; b < W; b++) begin : g_edge
      assign rise[b] = lvl[b] & ~prev[b];
      assign fall[b] = ~lvl[b] & prev[b];
    end
  endgenerate

  p_edge_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/sep_low_meter.sv
module sep_low_meter #(
  parameter int THR = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_lvl,
  output logic arm
);
  localparam int CW = $clog2(THR + 1);
  localparam logic [CW-1:0] LIM    = CW'(THR);
  localparam logic [CW-1:0] LIM_M1 = CW'(THR - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cs_lvl)      cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign arm = !cs_lvl && (cnt == LIM_M1);

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
  p_arm_once_r7: assert property (@(posedge clk) disable iff (rst)
    arm |=> !arm);
  p_arm_low_r4: assert property (@(posedge clk) disable iff (rst)
    arm |-> !$past(cs_lvl));
endmodule

// File: rtl/sep_vdet.sv
module sep_vdet
  import sep_pkg::*;
#(
  parameter int OFF_A = 4,
  parameter int OFF_B = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic mode,
  input  logic cs_lvl,
  input  logic cs_fall,
  input  logic tm_rise,
  input  logic tm_fall,
  input  logic enable,
  output logic vsep_o,
  output logic shape_o
);
  localparam int OW = $clog2(OFF_B + 1);
  localparam logic [OW-1:0] AT_A = OW'(OFF_A);
  localparam logic [OW-1:0] AT_B = OW'(OFF_B);

  vstate_e       state;
  logic          seen;
  logic          track;
  logic [OW-1:0] ocnt;
  logic          lvl_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= VS_IDLE;
      seen   <= 1'b0;
      vsep_o <= 1'b0;
    end else begin
      vsep_o <= 1'b0;
      if (arm) begin
        state <= mode ? VS_WAIT_LOW : VS_WAIT_RISE;
        seen  <= 1'b0;
      end else begin
        unique case (state)
          VS_WAIT_RISE: if (tm_rise) begin
            vsep_o <= enable;
            state  <= VS_IDLE;
          end
          VS_WAIT_LOW: if (tm_fall) begin
            state <= VS_WATCH;
            seen  <= cs_fall;
          end
          VS_WATCH: begin
            if (tm_rise) begin
              vsep_o <= enable & (seen | cs_fall);
              state  <= VS_IDLE;
            end else if (cs_fall) begin
              seen <= 1'b1;
            end
          end
          default: state <= VS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      track   <= 1'b0;
      ocnt    <= '0;
      lvl_a   <= 1'b0;
      shape_o <= 1'b0;
    end else if (arm) begin
      track <= 1'b1;
      ocnt  <= '0;
    end else if (track) begin
      ocnt <= ocnt + 1'b1;
      if (ocnt == AT_A) lvl_a <= cs_lvl;
      if (ocnt == AT_B) begin
        shape_o <= lvl_a ^ cs_lvl;
        track   <= 1'b0;
      end
    end
  end

  p_vsep_single_r10: assert property (@(posedge clk) disable iff (rst)
    vsep_o |=> !vsep_o);
  p_vsep_src_r6: assert property (@(posedge clk) disable iff (rst)
    vsep_o |-> ($past(state) == VS_WAIT_RISE || $past(state) == VS_WATCH));
  p_watch_need_r6: assert property (@(posedge clk) disable iff (rst)
    (state == VS_WATCH && tm_rise && !seen && !cs_fall && !arm) |=> !vsep_o);
  p_shape_upd_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(shape_o) |-> $past(track && ocnt == AT_B));
endmodule

// File: rtl/sync_separator.sv
module sync_separator #(
  parameter int LOW_THR        = 64,
  parameter int OFF_A          = 4,
  parameter int OFF_B          = 24,
  parameter int SETTLE_PERIODS = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  input  logic timing_in,
  input  logic vmode,
  output logic hsep_o,
  output logic vsep_o,
  output logic shape_o
);
  localparam int SW = $clog2(SETTLE_PERIODS + 1);
  localparam logic [SW-1:0] SETTLE_LIM = SW'(SETTLE_PERIODS);

  logic [1:0] lvl, rise, fall;
  logic arm;
  logic [SW-1:0] scnt;
  logic settled;

  sep_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .din({timing_in, csync_n}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  sep_low_meter #(.THR(LOW_THR)) u_meter (
    .clk(clk), .rst(rst), .cs_lvl(lvl[0]), .arm(arm)
  );

  always_ff @(posedge clk) begin
    if (rst)                    scnt <= '0;
    else if (!settled && rise[1]) scnt <= scnt + 1'b1;
  end
  assign settled = (scnt == SETTLE_LIM);

  always_ff @(posedge clk) begin
    if (rst) hsep_o <= 1'b0;
    else     hsep_o <= fall[0] & settled;
  end

  sep_vdet #(.OFF_A(OFF_A), .OFF_B(OFF_B)) u_vdet (
    .clk(clk), .rst(rst), .arm(arm), .mode(vmode),
    .cs_lvl(lvl[0]), .cs_fall(fall[0]),
    .tm_rise(rise[1]), .tm_fall(fall[1]),
    .enable(settled), .vsep_o(vsep_o), .shape_o(shape_o)
  );

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !settled |=> (!hsep_o && !vsep_o));
  p_settle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    settled |=> settled);
  p_hsep_single_r2: assert property (@(posedge clk) disable iff (rst)
    hsep_o |=> !hsep_o);
endmodule

// File: tb/tb_sync_separator.sv
module tb_sync_separator;
  localparam int THR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic timing_in = 1'b0;
  logic vmode = 1'b0;
  logic hsep_o, vsep_o, shape_o;

  int checks = 0, errors = 0;
  int cyc = 0, hcnt = 0, vcnt = 0, hlast = -1, vlast = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_separator #(.LOW_THR(THR), .OFF_A(2), .OFF_B(10), .SETTLE_PERIODS(2)) dut (
    .clk(clk), .rst(rst), .csync_n(csync_n), .timing_in(timing_in),
    .vmode(vmode), .hsep_o(hsep_o), .vsep_o(vsep_o), .shape_o(shape_o)
  );

  always @(posedge clk) begin
    if (!rst && hsep_o) begin hcnt++; hlast = cyc; end
    if (!rst && vsep_o) begin vcnt++; vlast = cyc; end
    cyc <= cyc + 1;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v0, h0, n;
    step(4);
    chk({hsep_o, vsep_o, shape_o} == 3'b000, "R1 in reset", {hsep_o, vsep_o, shape_o}, 0);
    rst = 1'b0;
    step(1);
    chk({hsep_o, vsep_o, shape_o} == 3'b000, "R1 after reset", {hsep_o, vsep_o, shape_o}, 0);

    // R3: outputs quiet before two timing rises
    csync_n = 1'b0; step(3); csync_n = 1'b1; step(4);
    timing_in = 1'b1; step(4); timing_in = 1'b0; step(4);
    chk(hcnt == 0, "R3 hsep suppressed", hcnt, 0);
    csync_n = 1'b0; step(3); csync_n = 1'b1; step(4);
    chk(hcnt == 0, "R3 hsep still suppressed", hcnt, 0);
    timing_in = 1'b1; step(4); timing_in = 1'b0; step(4);
    chk(vcnt == 0, "R3 vsep suppressed", vcnt, 0);

    // R2: falling edges after settling
    for (int k = 0; k < 5; k++) begin
      h0 = hcnt; n = cyc;
      csync_n = 1'b0; step(3); csync_n = 1'b1; step(4);
      chk(hcnt == h0 + 1, "R2 one pulse per falling edge", hcnt - h0, 1);
      chk(hlast == n + 3, "R2 latency", hlast - n, 3);
    end

    // R4/R5: method 0 low-width sweep around threshold
    for (int w = THR - 2; w <= THR + 2; w++) begin
      v0 = vcnt;
      csync_n = 1'b0; step(w); csync_n = 1'b1; step(4);
      timing_in = 1'b1; n = cyc; step(4); timing_in = 1'b0; step(6);
      chk(vcnt - v0 == (w >= THR ? 1 : 0), "R4 threshold", vcnt - v0, (w >= THR ? 1 : 0));
      if (w >= THR) chk(vlast == n + 3, "R5 vsep on next timing rise", vlast - n, 3);
    end

    // R7: long low qualifies only once
    v0 = vcnt;
    csync_n = 1'b0; step(THR + 5);
    timing_in = 1'b1; n = cyc; step(3); timing_in = 1'b0; step(THR * 2);
    timing_in = 1'b1; step(3); timing_in = 1'b0; step(THR);
    csync_n = 1'b1; step(6);
    chk(vcnt - v0 == 1, "R7 single vsep per low interval", vcnt - v0, 1);
    chk(vlast == n + 3, "R7 pulse at first rise", vlast - n, 3);

    // R8: mode sampled at qualification
    v0 = vcnt; vmode = 1'b0;
    csync_n = 1'b0; step(THR + 3); csync_n = 1'b1; step(2);
    vmode = 1'b1; step(3);
    timing_in = 1'b1; n = cyc; step(4); timing_in = 1'b0; step(6);
    chk(vcnt - v0 == 1 && vlast == n + 3, "R8 latched method 0", vcnt - v0, 1);

    // R6/R10: method 1 sweep over falling-edge placement
    vmode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      v0 = vcnt;
      csync_n = 1'b0; step(THR + 3); csync_n = 1'b1; step(4);
      timing_in = 1'b1; step(5);
      if (c == 1) begin csync_n = 1'b0; step(2); csync_n = 1'b1; end
      step(4);
      timing_in = 1'b0; step(3);
      if (c == 2) begin csync_n = 1'b0; step(2); csync_n = 1'b1; step(4); end
      else step(6);
      timing_in = 1'b1; n = cyc;
      if (c == 3) csync_n = 1'b0;
      step(4); timing_in = 1'b0;
      if (c == 3) csync_n = 1'b1;
      step(6);
      chk(vcnt - v0 == (c >= 2 ? 1 : 0), "R6 qualified by fall in low phase", vcnt - v0, (c >= 2 ? 1 : 0));
      if (c >= 2) chk(vlast == n + 3, "R6 vsep at closing rise", vlast - n, 3);
      if (c == 3) chk(hlast == vlast, "R10 hsep and vsep coincide", hlast, vlast);
    end

    // R9: shape flag
    vmode = 1'b0;
    csync_n = 1'b0; step(30); csync_n = 1'b1; step(20);
    chk(shape_o == 1'b0, "R9 plain low region", shape_o, 0);
    csync_n = 1'b0; step(14); csync_n = 1'b1; step(25);
    chk(shape_o == 1'b1, "R9 mismatched region", shape_o, 1);
    csync_n = 1'b0; step(30); csync_n = 1'b1; step(20);
    chk(shape_o == 1'b0, "R9 back to match", shape_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule